// File: doc/BRIEF.md
# Standby Mode and Pin-Drive Controller

This controller puts a small processor subsystem into one of three low-power states when the core raises a halt strobe. A 2-bit field in a control register picks the state. The lightest state, IDLE2, stops only the processor clock, and any peripheral whose keep-running bit is set goes on being clocked. IDLE1 leaves only the oscillator, the real-time clock and the melody/alarm block clocked. STOP gates every clock domain, the oscillator included.

While the controller is in standby, it also owns the output and input buffer enables of an 8-pin port. For each pin, a per-pin standby drive bit is combined with the pin's output enable, captured at the moment of entry, to choose the buffer state. Outside standby, the buffers follow the port direction bits. An enabled wake-up line returns the block to run mode on the next clock edge.

Top module: `standby_ctrl`

## Requirements
- R1: After reset the block is in run mode (`mode_state`=00). Every clock enable is 1. The mode field reads 0, the drive register reads 8'hFF, and the keep-running and wake-enable registers read 0.
- R2: In run mode, a `halt_req` with mode field 01, 10 or 11 sets `mode_state` to that code (01=STOP, 10=IDLE1, 11=IDLE2) at the next clock edge.
- R3: In run mode, a `halt_req` with mode field 00 is ignored. The block stays in run mode with all clocks enabled.
- R4: In IDLE2 the CPU clock enable is 0, and the oscillator, RTC and melody enables are 1. Peripheral enable bit i equals keep-running bit i. Bits 0-5 are the timers, bit 6 serial, bit 7 serial bus, bit 8 ADC and bit 9 watchdog.
- R5: In IDLE1 only the oscillator, RTC and melody enables are 1. The CPU enable and all peripheral enables are 0.
- R6: In STOP every clock enable output is 0.
- R7: In any standby mode, pin n follows the latched output enable OE[n] and the drive bit D[n]. With D=0 both buffers are off. With D=1 and OE=1 only the output buffer is on. With D=1 and OE=0 only the input buffer is on.
- R8: In run mode `pin_out_en` equals `port_oe` and `pin_in_en` equals `~port_oe`. Writes to the drive register have no effect on the pins in run mode.
- R9: `port_oe` is captured on the entry edge. Changes to `port_oe` during standby do not change the pin enables.
- R10: In standby, a `wake_irq` line whose wake-enable bit is set returns the block to run mode at the next edge, which restores all clock enables and run-mode pin control. Wake lines whose enable bit is clear are ignored.
- R11: A `halt_req` during standby does not change the mode.
- R12: Registers are written with `reg_wr` and read combinationally on `reg_rdata`, zero-extended. Address 0 is the mode field [1:0], 1 the drive register [7:0], 2 the keep-running bits [9:0] and 3 the wake-enable bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| halt_req | input | 1 | Halt request from the core |
| wake_irq | input | 4 | Wake-up interrupt lines |
| port_oe | input | 8 | Port direction bits (1 = output) |
| mode_state | output | 2 | Current mode: 00 run, 01 STOP, 10 IDLE1, 11 IDLE2 |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_per | output | 10 | Peripheral clock enables |
| clk_en_osc | output | 1 | Oscillator enable |
| clk_en_rtc | output | 1 | Real-time clock enable |
| clk_en_mld | output | 1 | Melody/alarm clock enable |
| pin_out_en | output | 8 | Per-pin output buffer enable |
| pin_in_en | output | 8 | Per-pin input buffer enable |

## Verification
The assertions assume that `halt_req`, `wake_irq` and register writes are synchronous and settle before each rising edge. They also assume that a mode code sampled with a halt is the register value, not the value being written on that same edge. The bench drives every input on the falling edge. It pulses each strobe for exactly one cycle and keeps register writes in separate cycles from halt pulses, so no edge ever sees a write and a halt together. Wake pulses are issued only after the standby state has been sampled.

// File: rtl/standby_ctrl.sv
module standby_ctrl #(
  parameter int NPIN  = 8,
  parameter int NPER  = 10,
  parameter int NWAKE = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             halt_req,
  input  logic [NWAKE-1:0] wake_irq,
  input  logic [NPIN-1:0]  port_oe,
  output logic [1:0]       mode_state,
  output logic             clk_en_cpu,
  output logic [NPER-1:0]  clk_en_per,
  output logic             clk_en_osc,
  output logic             clk_en_rtc,
  output logic             clk_en_mld,
  output logic [NPIN-1:0]  pin_out_en,
  output logic [NPIN-1:0]  pin_in_en
);
  localparam logic [1:0] M_RUN   = 2'b00;
  localparam logic [1:0] M_STOP  = 2'b01;
  localparam logic [1:0] M_IDLE1 = 2'b10;
  localparam logic [1:0] M_IDLE2 = 2'b11;

  logic [1:0]       st, mode_f;
  logic [NPIN-1:0]  drv, oe_lat;
  logic [NPER-1:0]  keep;
  logic [NWAKE-1:0] wake_en;
  logic             in_sb, wake_hit;

  assign in_sb    = st != M_RUN;
  assign wake_hit = |(wake_irq & wake_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= M_RUN;
      mode_f  <= M_RUN;
      drv     <= '1;
      keep    <= '0;
      wake_en <= '0;
      oe_lat  <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          2'd0:    mode_f  <= reg_wdata[1:0];
          2'd1:    drv     <= reg_wdata[NPIN-1:0];
          2'd2:    keep    <= reg_wdata[NPER-1:0];
          default: wake_en <= reg_wdata[NWAKE-1:0];
        endcase
      end
      if (!in_sb && halt_req && mode_f != M_RUN) begin
        st     <= mode_f;
        oe_lat <= port_oe;
      end else if (in_sb && wake_hit) begin
        st <= M_RUN;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = DW'(mode_f);
      2'd1:    reg_rdata = DW'(drv);
      2'd2:    reg_rdata = DW'(keep);
      default: reg_rdata = DW'(wake_en);
    endcase
  end

  assign mode_state = st;
  assign clk_en_cpu = !in_sb;
  assign clk_en_per = !in_sb ? '1 : (st == M_IDLE2 ? keep : '0);
  assign clk_en_osc = st != M_STOP;
  assign clk_en_rtc = st != M_STOP;
  assign clk_en_mld = st != M_STOP;
  assign pin_out_en = in_sb ? (oe_lat & drv)  : port_oe;
  assign pin_in_en  = in_sb ? (~oe_lat & drv) : ~port_oe;

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sb && halt_req && mode_f != M_RUN) |=> mode_state == $past(mode_f));
  p_reserved_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sb && halt_req && mode_f == M_RUN) |=> (mode_state == M_RUN && clk_en_cpu));
  p_idle2_clocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == M_IDLE2) |-> (!clk_en_cpu && clk_en_osc && clk_en_rtc && clk_en_per == keep));
  p_idle1_clocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == M_IDLE1) |-> (!clk_en_cpu && clk_en_osc && clk_en_mld && clk_en_per == '0));
  p_stop_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == M_STOP) |-> (!clk_en_cpu && !clk_en_osc && !clk_en_rtc && !clk_en_mld
                                && clk_en_per == '0));
  p_buf_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_sb |-> (pin_out_en & pin_in_en) == '0);
  p_oe_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sb && $past(in_sb) && $stable(drv)) |-> $stable(pin_out_en));
  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sb && wake_hit) |=> (mode_state == M_RUN && clk_en_osc && clk_en_cpu));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sb && !wake_hit) |=> $stable(mode_state));
endmodule

// File: tb/standby_ctrl_bench.sv
module standby_ctrl_bench;
  logic        clk = 0, rst_n = 0, reg_wr = 0, halt_req = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [3:0]  wake_irq = 0;
  logic [7:0]  port_oe = 0, pin_out_en, pin_in_en;
  logic [1:0]  mode_state;
  logic        clk_en_cpu, clk_en_osc, clk_en_rtc, clk_en_mld;
  logic [9:0]  clk_en_per;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  standby_ctrl u_standby_ctrl (.*);

  // {mode, keep, drive, oe, exp_state, exp_cpu, exp_per, exp_osc, exp_out, exp_in}
  localparam logic [57:0] VEC [6] = '{
    {2'b01, 10'h3FF, 8'hF0, 8'hCC, 2'b01, 1'b0, 10'h000, 1'b0, 8'hC0, 8'h30},
    {2'b10, 10'h3FF, 8'h0F, 8'h3C, 2'b10, 1'b0, 10'h000, 1'b1, 8'h0C, 8'h03},
    {2'b11, 10'h2A5, 8'hFF, 8'hA5, 2'b11, 1'b0, 10'h2A5, 1'b1, 8'hA5, 8'h5A},
    {2'b11, 10'h15A, 8'h00, 8'hFF, 2'b11, 1'b0, 10'h15A, 1'b1, 8'h00, 8'h00},
    {2'b10, 10'h000, 8'hAA, 8'h00, 2'b10, 1'b0, 10'h000, 1'b1, 8'h00, 8'hAA},
    {2'b00, 10'h3FF, 8'h00, 8'h0F, 2'b00, 1'b1, 10'h3FF, 1'b1, 8'h0F, 8'hF0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic halt_pulse;
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0;
  endtask

  task automatic wake_pulse(input logic [3:0] w);
    @(negedge clk); wake_irq = w;
    @(negedge clk); wake_irq = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", mode_state, 2'b00);
    chk("R1 clocks", {clk_en_cpu, clk_en_per, clk_en_osc, clk_en_rtc, clk_en_mld}, 14'h3FFF);
    rd(2'd0, d); chk("R1 R12 mode", d, 16'h0000);
    rd(2'd1, d); chk("R1 R12 drive", d, 16'h00FF);
    rd(2'd2, d); chk("R1 R12 keep", d, 16'h0000);
    rd(2'd3, d); chk("R1 R12 wake", d, 16'h0000);
    chk("R8 run pins", {pin_out_en, pin_in_en}, 16'h00FF);

    wr(2'd3, 16'h0001);
    rd(2'd3, d); chk("R12 wake readback", d, 16'h0001);

    foreach (VEC[i]) begin
      logic [57:0] v;
      string ctag, ptag;
      v = VEC[i];
      case (v[57:56])
        2'b01: ctag = "R6"; 2'b10: ctag = "R5";
        2'b11: ctag = "R4"; default: ctag = "R3";
      endcase
      ptag = (v[57:56] == 2'b00) ? "R8" : "R7";
      wr(2'd0, {14'd0, v[57:56]});
      wr(2'd2, {6'd0, v[55:46]});
      wr(2'd1, {8'd0, v[45:38]});
      rd(2'd2, d); chk("R12 keep readback", d, {6'd0, v[55:46]});
      port_oe = v[37:30];
      halt_pulse();
      chk("R2 mode", mode_state, v[29:28]);
      chk({ctag, " cpu"}, clk_en_cpu, v[27]);
      chk({ctag, " per"}, clk_en_per, v[26:17]);
      chk({ctag, " osc/rtc/mld"}, {clk_en_osc, clk_en_rtc, clk_en_mld}, {3{v[16]}});
      chk({ptag, " out_en"}, pin_out_en, v[15:8]);
      chk({ptag, " in_en"}, pin_in_en, v[7:0]);
      wake_pulse(4'b0001);
      chk("R10 back to run", mode_state, 2'b00);
    end

    // R9: OE frozen in standby
    wr(2'd1, 16'h00FF); wr(2'd2, 16'h0000); wr(2'd0, 16'h0003);
    port_oe = 8'h0F;
    halt_pulse();
    chk("R4 idle2 per off", clk_en_per, 10'h000);
    port_oe = 8'hF0;
    @(negedge clk);
    chk("R9 out frozen", pin_out_en, 8'h0F);
    chk("R9 in frozen", pin_in_en, 8'hF0);

    // R11: halt during standby ignored
    wr(2'd0, 16'h0001);
    halt_pulse();
    chk("R11 mode held", mode_state, 2'b11);
    chk("R11 osc still on", clk_en_osc, 1'b1);

    // R10: disabled wake line ignored, enabled one wakes
    wake_pulse(4'b1110);
    chk("R10 masked wake", mode_state, 2'b11);
    wake_pulse(4'b0001);
    chk("R10 wake state", mode_state, 2'b00);
    chk("R10 clocks restored", {clk_en_cpu, clk_en_per, clk_en_osc, clk_en_rtc, clk_en_mld}, 14'h3FFF);
    chk("R10 pins follow port", {pin_out_en, pin_in_en}, 16'hF00F);

    // R8: drive register has no effect in run mode
    wr(2'd1, 16'h0000);
    chk("R8 drive ignored", {pin_out_en, pin_in_en}, 16'hF00F);
    wake_pulse(4'b0001);
    chk("R10 wake in run harmless", mode_state, 2'b00);

    report();
  end
endmodule